// File: doc/BRIEF.md
# Single-precision normalise-and-round stage

This block is the last step of a single-precision arithmetic pipe. An upstream unit hands it an unpacked intermediate value: a sign, a signed biased exponent and a 32-bit significand that carries eight guard bits below the final result LSB. The stage turns that value into a packed IEEE-754 32-bit word. It moves the leading one up to bit 31 and handles tiny results by shifting them right with a sticky OR of every bit that falls off. It then rounds under one of four rounding modes, saturates on overflow, and packs the result. It also returns three exception flags, {overflow, underflow, inexact}, merged with any flags the producer already raised.

Two details matter on overflow and underflow. On overflow, a zero rounding increment gives the largest finite magnitude and any other increment gives infinity. Underflow is only reported when a result is both tiny and inexact. A value with exponent 255 passes straight to packing unchanged in two cases: its significand is zero, or it arrives with a flag already set. That is how producers forward infinities and NaNs they have already resolved.

Transfers use a valid/ready handshake with one registered output stage. The reset input is asynchronous, asserted low, and its release is synchronised inside the block.

Top module: `fpnr_stage`

## Requirements
- R1: When the exponent equals 255 and either the significand is zero or in_flags is nonzero, the word is {sign, 8'hFF, in_sig[29:7]} and the flags equal in_flags.
- R2: Otherwise a zero significand yields a signed zero {sign, 31'b0} and the flags equal in_flags.
- R3: A nonzero significand is shifted left until bit 31 is set, and the exponent is lowered by the same amount. The packed exponent field is the normalised exponent plus the hidden bit, so a significand with its top one at bit 30 and exponent E in 1..252 packs with exponent field E.
- R4: A negative normalised exponent shifts the significand right by its magnitude, ORing every lost bit into bit 0, and sets the exponent to 0. Underflow (flag bit 1) is raised only if guard bits [7:0] are nonzero after that shift, the rounded exponent is still 0, and the rounded significand does not exceed 0x80000000.
- R5: in_rmode 00 is round to nearest even, with an increment of 0x80, or 0x7F when bit 8 is 0. Mode 11 is toward zero (increment 0). Mode 01 is toward +inf and mode 10 is toward -inf; each adds 0xFF when the sign points that way and 0 otherwise.
- R6: When adding the increment would carry out of bit 31, the exponent is raised by 1 first. The significand is shifted right by 1 with its old bit 0 kept sticky, and the increment is halved.
- R7: Inexact (flag bit 0) is raised whenever significand bits [7:0] are nonzero before the increment is added.
- R8: An exponent of 254 or more after the carry step raises overflow and inexact (flag bits 2 and 0). A zero increment then gives magnitude 0x7F7FFFFF and any other increment gives 0x7F800000.
- R9: out_flags is {overflow, underflow, inexact} ORed bit by bit with the in_flags accepted with that value.
- R10: A value is accepted when in_valid and in_ready are both high. It appears on the outputs one cycle later and stays stable while out_valid is high and out_ready is low. in_ready is high when the register is empty or being drained.
- R11: While reset is active, and until its release has been synchronised, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Intermediate value present |
| in_ready | output | 1 | Stage can take a value this cycle |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | EXP_W | Signed two's-complement biased exponent |
| in_sig | input | 32 | Significand with eight guard bits |
| in_rmode | input | 2 | Rounding mode (see R5) |
| in_flags | input | 3 | Flags already raised {overflow, underflow, inexact} |
| out_valid | output | 1 | Packed result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed single-precision result |
| out_flags | output | 3 | {overflow, underflow, inexact} merged with in_flags |

## Verification
The bench builds the stage with the default EXP_W of 10, so the exponent input spans -512 to 511. That range reaches right shifts far beyond the 32 significand bits, where only the sticky bit survives, as well as exponents well past the overflow threshold of 254. Exponents are drawn between -100 and 300 together with significands that carry from 0 to 31 leading zeros. This mixes normal results, subnormals, flush-to-sticky cases, rounding carries and overflow in every rounding mode. Random back-pressure on out_ready exercises the hold behaviour of the output register.

// File: rtl/fpnr_pkg.sv
package fpnr_pkg;

  // packed single-precision layout
  localparam int SIG_W  = 32;
  localparam int FRAC_W = 23;
  localparam int EFLD_W = 8;
  // guard bits below the result LSB once the leading one sits at bit 31
  localparam int GRD    = SIG_W - FRAC_W - 2;
  localparam int FLAG_W = 3;

  // flag bit positions
  localparam int FLG_INX = 0;
  localparam int FLG_UNF = 1;
  localparam int FLG_OVF = 2;

  // rounding mode encodings
  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_UP   = 2'b01;
  localparam logic [1:0] RM_DOWN = 2'b10;
  localparam logic [1:0] RM_ZERO = 2'b11;

  localparam logic [EFLD_W-1:0] EXP_SPECIAL = '1;
  localparam int                EXP_OVF     = 254;

endpackage

// File: rtl/fpnr_lzc.sv
module fpnr_lzc #(
  parameter int W = 32
) (
  input  logic [W-1:0]         vec,
  output logic [$clog2(W):0]   cnt
);

  localparam int CW = $clog2(W) + 1;

  // highest set bit wins because it is visited last
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fpnr_prenorm.sv
module fpnr_prenorm
  import fpnr_pkg::*;
#(
  parameter int EI_W = 11
) (
  input  logic [SIG_W-1:0]        sig_i,
  input  logic signed [EI_W-1:0]  exp_i,
  output logic [SIG_W-1:0]        sig_o,
  output logic signed [EI_W-1:0]  exp_o,
  output logic                    tiny_o
);

  localparam int SH_W = $clog2(SIG_W);

  logic [SH_W:0]           lz;
  logic [SIG_W-1:0]        nsig;
  logic [SIG_W-1:0]        kept;
  logic [SIG_W-1:0]        lost_mask;
  logic signed [EI_W-1:0]  nexp;
  logic [EI_W-1:0]         rsh;
  logic                    far;
  logic                    sticky;

  fpnr_lzc #(.W(SIG_W)) u_lzc (
    .vec (sig_i),
    .cnt (lz)
  );

  always_comb begin
    // left-justify the leading one
    nsig = sig_i << lz;
    nexp = exp_i - $signed({{(EI_W-SH_W-1){1'b0}}, lz});

    // right shift amount for tiny values, with sticky collection
    rsh       = -nexp;
    far       = (rsh >= EI_W'(SIG_W));
    lost_mask = ~({SIG_W{1'b1}} << rsh[SH_W-1:0]);
    kept      = nsig >> rsh[SH_W-1:0];
    sticky    = far ? (|nsig) : (|(nsig & lost_mask));

    if (nexp[EI_W-1]) begin
      sig_o  = far ? {{(SIG_W-1){1'b0}}, sticky}
                   : (kept | {{(SIG_W-1){1'b0}}, sticky});
      exp_o  = '0;
      tiny_o = |sig_o[GRD:0];
    end else begin
      sig_o  = nsig;
      exp_o  = nexp;
      tiny_o = 1'b0;
    end
  end

endmodule

// File: rtl/fpnr_round.sv
module fpnr_round
  import fpnr_pkg::*;
#(
  parameter int EI_W = 11
) (
  input  logic                    sign_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic signed [EI_W-1:0]  exp_i,
  input  logic                    tiny_i,
  input  logic [1:0]              rmode_i,
  output logic [SIG_W-1:0]        word_o,
  output logic [FLAG_W-1:0]       flags_o
);

  localparam logic [SIG_W-1:0] INC_HALF = SIG_W'(1) << GRD;
  localparam logic [SIG_W-1:0] INC_FULL = (SIG_W'(1) << (GRD + 1)) - SIG_W'(1);
  localparam logic [SIG_W-1:0] SIG_MSB  = SIG_W'(1) << (SIG_W - 1);
  localparam logic signed [EI_W-1:0] OVF_E = EI_W'(EXP_OVF);
  localparam logic [SIG_W-2:0] MAG_MAX  = {EXP_SPECIAL - EFLD_W'(1), {FRAC_W{1'b1}}};
  localparam logic [SIG_W-2:0] MAG_INF  = {EXP_SPECIAL, {FRAC_W{1'b0}}};

  logic [SIG_W-1:0]        inc;
  logic [SIG_W-1:0]        inc_adj;
  logic [SIG_W:0]          trial;
  logic [SIG_W-1:0]        sig_adj;
  logic [SIG_W-1:0]        rnd;
  logic signed [EI_W-1:0]  exp_adj;
  logic [EFLD_W-1:0]       efld;
  logic [SIG_W-2:0]        packed_mag;
  logic                    inx;
  logic                    unf;
  logic                    big;

  // increment selection
  always_comb begin
    unique case (rmode_i)
      RM_NEAR: inc = sig_i[GRD+1] ? INC_HALF : (INC_HALF - SIG_W'(1));
      RM_UP:   inc = sign_i ? '0 : INC_FULL;
      RM_DOWN: inc = sign_i ? INC_FULL : '0;
      default: inc = '0;
    endcase
  end

  // carry pre-adjust, rounding, range checks
  always_comb begin
    trial = {1'b0, sig_i} + {1'b0, inc};
    if (trial[SIG_W]) begin
      exp_adj = exp_i + EI_W'(1);
      sig_adj = {1'b0, sig_i[SIG_W-1:1]} | {{(SIG_W-1){1'b0}}, sig_i[0]};
      inc_adj = inc >> 1;
    end else begin
      exp_adj = exp_i;
      sig_adj = sig_i;
      inc_adj = inc;
    end

    inx = |sig_adj[GRD:0];
    rnd = sig_adj + inc_adj;
    big = (exp_adj >= OVF_E);

    efld = (~|rnd[SIG_W-1:GRD+1]) ? '0 : exp_adj[EFLD_W-1:0];
    unf  = tiny_i && (efld == '0) && (rnd <= SIG_MSB);

    packed_mag = {efld, {FRAC_W{1'b0}}}
               + {{(EFLD_W-1){1'b0}}, rnd[SIG_W-1:GRD+1]};

    if (big) begin
      word_o  = {sign_i, (inc_adj == '0) ? MAG_MAX : MAG_INF};
      flags_o = '0;
      flags_o[FLG_OVF] = 1'b1;
      flags_o[FLG_INX] = 1'b1;
    end else begin
      word_o  = {sign_i, packed_mag};
      flags_o = '0;
      flags_o[FLG_UNF] = unf;
      flags_o[FLG_INX] = inx;
    end
  end

endmodule

// File: rtl/fpnr_hold.sv
module fpnr_hold #(
  parameter int DW = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);

  logic          vld_q;
  logic          vld_d;
  logic [DW-1:0] dat_q;
  logic          load;

  assign up_ready = rst_n & (~vld_q | dn_ready);
  assign load     = up_valid & up_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)          vld_d = 1'b1;
    else if (dn_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) dat_q <= up_data;
    end
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

endmodule

// File: rtl/fpnr_stage.sv
module fpnr_stage
  import fpnr_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [31:0]       in_sig,
  input  logic [1:0]        in_rmode,
  input  logic [2:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_word,
  output logic [2:0]        out_flags
);

  localparam int EI_W = EXP_W + 1;
  localparam int DW   = FLAG_W + SIG_W;
  localparam logic signed [EI_W-1:0] SPECIAL_E = EI_W'(255);

  // reset: asynchronous assert, synchronised release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic signed [EI_W-1:0] exp_ext;
  logic [SIG_W-1:0]       pn_sig;
  logic signed [EI_W-1:0] pn_exp;
  logic                   pn_tiny;
  logic [SIG_W-1:0]       rd_word;
  logic [FLAG_W-1:0]      rd_flags;
  logic                   pass_thru;
  logic                   sig_zero;
  logic [SIG_W-1:0]       res_word;
  logic [FLAG_W-1:0]      res_flags;
  logic [DW-1:0]          hold_q;

  assign exp_ext = $signed({in_exp[EXP_W-1], in_exp});

  fpnr_prenorm #(.EI_W(EI_W)) u_prenorm (
    .sig_i  (in_sig),
    .exp_i  (exp_ext),
    .sig_o  (pn_sig),
    .exp_o  (pn_exp),
    .tiny_o (pn_tiny)
  );

  fpnr_round #(.EI_W(EI_W)) u_round (
    .sign_i  (in_sign),
    .sig_i   (pn_sig),
    .exp_i   (pn_exp),
    .tiny_i  (pn_tiny),
    .rmode_i (in_rmode),
    .word_o  (rd_word),
    .flags_o (rd_flags)
  );

  // result selection
  always_comb begin
    sig_zero  = ~|in_sig;
    pass_thru = (exp_ext == SPECIAL_E) && (sig_zero || (|in_flags));
    if (pass_thru) begin
      res_word  = {in_sign, EXP_SPECIAL, in_sig[GRD+FRAC_W-1:GRD]};
      res_flags = in_flags;
    end else if (sig_zero) begin
      res_word  = {in_sign, {(SIG_W-1){1'b0}}};
      res_flags = in_flags;
    end else begin
      res_word  = rd_word;
      res_flags = rd_flags | in_flags;
    end
  end

  fpnr_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({res_flags, res_word}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (hold_q)
  );

  assign out_flags = hold_q[DW-1:SIG_W];
  assign out_word  = hold_q[SIG_W-1:0];

endmodule

// File: rtl/fpnr_stage_chk.sv
module fpnr_stage_chk #(
  parameter int EXP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sign,
  input logic [EXP_W-1:0] in_exp,
  input logic [31:0]      in_sig,
  input logic [1:0]       in_rmode,
  input logic [2:0]       in_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_word,
  input logic [2:0]       out_flags
);

  logic accept;
  logic special;
  assign accept  = in_valid && in_ready;
  assign special = (in_exp == EXP_W'(255)) && ((in_sig == 32'd0) || (in_flags != 3'd0));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_flags));

  // R10
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((out_flags & $past(in_flags)) == $past(in_flags)));

  // R2
  signed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_sig == 32'd0) && (in_exp != EXP_W'(255))
      |=> out_word == {$past(in_sign), 31'd0});

  // R1
  inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_sig == 32'd0) && (in_exp == EXP_W'(255))
      |=> out_word == {$past(in_sign), 8'hFF, 23'd0} && out_flags == $past(in_flags));

  // R8
  rz_finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_rmode == 2'b11) && !special |=> out_word[30:23] != 8'hFF);

  // R4
  unf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_flags[1] |=> !out_flags[1] || (out_word[30:23] <= 8'd1));

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid && !in_ready);
    end
  end

endmodule

bind fpnr_stage fpnr_stage_chk #(.EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sign   (in_sign),
  .in_exp    (in_exp),
  .in_sig    (in_sig),
  .in_rmode  (in_rmode),
  .in_flags  (in_flags),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_flags (out_flags)
);

// File: tb/fpnr_stage_tb_top.sv
`timescale 1ns/1ps
module fpnr_stage_tb_top;

  localparam int EXP_W = 10;
  localparam int HALF  = 10;
  localparam int WD_CYCLES = 150000;

  logic             clk = 1'b0;
  logic             arst_n;
  logic             in_valid;
  logic             in_ready;
  logic             in_sign;
  logic [EXP_W-1:0] in_exp;
  logic [31:0]      in_sig;
  logic [1:0]       in_rmode;
  logic [2:0]       in_flags;
  logic             out_valid;
  logic             out_ready;
  logic [31:0]      out_word;
  logic [2:0]       out_flags;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;
  bit  bp_on    = 0;
  bit  live     = 0;

  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #HALF clk = ~clk;

  fpnr_stage #(.EXP_W(EXP_W)) dut_i (
    .clk       (clk),
    .arst_n    (arst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sign   (in_sign),
    .in_exp    (in_exp),
    .in_sig    (in_sig),
    .in_rmode  (in_rmode),
    .in_flags  (in_flags),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_flags (out_flags)
  );

  // behavioural model written from the requirements
  function automatic logic [34:0] model(bit s, int e, bit [31:0] m, bit [1:0] rm, bit [2:0] fi);
    bit [31:0] sg;
    bit [31:0] inc;
    bit [32:0] sum;
    int        ex;
    bit        tiny, inx, unf;
    if (e == 255 && (m == 0 || fi != 0)) return {fi, s, 8'hFF, m[29:7]};   // R1
    if (m == 0) return {fi, s, 31'd0};                                      // R2
    sg = m; ex = e;
    while (!sg[31]) begin sg = {sg[30:0], 1'b0}; ex = ex - 1; end         // R3
    tiny = 0;
    if (ex < 0) begin                                                       // R4
      int n;
      bit st;
      n = -ex; st = 0;
      for (int k = 0; k < n && k < 40; k++) begin st |= sg[0]; sg = sg >> 1; end
      sg[0] = sg[0] | st;
      ex = 0;
      tiny = (sg[7:0] != 0);
    end
    case (rm)                                                               // R5
      2'b00:   inc = sg[8] ? 32'h80 : 32'h7F;
      2'b01:   inc = s ? 32'h0 : 32'hFF;
      2'b10:   inc = s ? 32'hFF : 32'h0;
      default: inc = 32'h0;
    endcase
    sum = {1'b0, sg} + {1'b0, inc};
    if (sum[32]) begin                                                      // R6
      ex = ex + 1;
      sg = {1'b0, sg[31:1]} | {31'd0, sg[0]};
      inc = inc >> 1;
    end
    inx = (sg[7:0] != 0);                                                   // R7
    sg = sg + inc;
    if (ex >= 254) return {fi | 3'b101, s, (inc == 0) ? 31'h7F7FFFFF : 31'h7F800000}; // R8
    if (sg[31:8] == 0) ex = 0;
    unf = tiny && ex == 0 && sg <= 32'h80000000;
    return {fi | {1'b0, unf, inx}, s, 31'(ex * (1 << 23) + int'(sg[31:8]))};      // R9
  endfunction

  task automatic drive(input bit s, input int e, input bit [31:0] m, input bit [1:0] rm,
                       input bit [2:0] fi, input logic [34:0] expv, input string tag);
    bit acc;
    acc = 0;
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = EXP_W'(e); in_sig = m; in_rmode = rm; in_flags = fi;
    while (!acc) begin
      #(HALF - 1);
      if (in_ready) begin
        acc = 1;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(posedge clk);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic send(input bit s, input int e, input bit [31:0] m, input bit [1:0] rm,
                      input bit [2:0] fi, input string tag);
    drive(s, e, m, rm, fi, model(s, e, m, rm, fi), tag);
  endtask

  // consumer back-pressure
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic [34:0] prev;
    logic [34:0] want;
    string       tg;
    bit          stalled;
    stalled = 0; prev = '0;
    forever begin
      @(negedge clk);
      #(HALF - 1);
      if (live) begin
        if (stalled) begin
          n_checks++;
          if (out_valid !== 1'b1 || {out_flags, out_word} !== prev) begin
            n_fails++;
            $display("FAIL R10 hold: got v=%b %h expected v=1 %h", out_valid, {out_flags, out_word}, prev);
          end
        end
        if (out_valid && out_ready) begin
          n_checks++;
          if (exp_q.size() == 0) begin
            n_fails++;
            $display("FAIL R10 spurious output: got %h expected none", {out_flags, out_word});
          end else begin
            want = exp_q.pop_front();
            tg   = tag_q.pop_front();
            if ({out_flags, out_word} !== want) begin
              n_fails++;
              $display("FAIL %s: got flags=%b word=%h expected flags=%b word=%h",
                       tg, out_flags, out_word, want[34:32], want[31:0]);
            end
          end
        end
        stalled = out_valid && !out_ready;
        prev    = {out_flags, out_word};
      end
    end
  end

  // watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0;
    in_sig = '0; in_rmode = 2'b00; in_flags = 3'b000;
    repeat (3) @(negedge clk);
    n_checks++;   // R11 during reset
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      n_fails++;
      $display("FAIL R11: got v=%b r=%b expected v=0 r=0", out_valid, in_ready);
    end
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;   // R11 after release
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fails++;
      $display("FAIL R11: got v=%b r=%b expected v=0 r=1", out_valid, in_ready);
    end
    live = 1;

    // hand-computed directed cases
    drive(0, 127, 32'h40000000, 2'b00, 3'b000, {3'b000, 32'h3F800000}, "R3 one");
    drive(0, 130, 32'h00400000, 2'b00, 3'b000, {3'b000, 32'h3D000000}, "R3 shift9");
    drive(0, 126, 32'h80000080, 2'b00, 3'b000, {3'b001, 32'h3F800000}, "R5 tie even");
    drive(0, 126, 32'h80000180, 2'b00, 3'b000, {3'b001, 32'h3F800002}, "R5 tie odd");
    drive(0, 126, 32'h80000001, 2'b01, 3'b000, {3'b001, 32'h3F800001}, "R5 up pos");
    drive(1, 126, 32'h80000001, 2'b01, 3'b000, {3'b001, 32'hBF800000}, "R5 up neg");
    drive(1, 126, 32'h80000001, 2'b10, 3'b000, {3'b001, 32'hBF800001}, "R5 down neg");
    drive(0, 126, 32'h800001FF, 2'b11, 3'b000, {3'b001, 32'h3F800001}, "R5 zero");
    drive(0, 126, 32'hFFFFFFFF, 2'b00, 3'b000, {3'b001, 32'h40000000}, "R6 carry");
    drive(0, 126, 32'h80000100, 2'b00, 3'b000, {3'b000, 32'h3F800001}, "R7 exact");
    drive(0, 300, 32'h80000000, 2'b00, 3'b000, {3'b101, 32'h7F800000}, "R8 inf");
    drive(0, 300, 32'h80000000, 2'b11, 3'b000, {3'b101, 32'h7F7FFFFF}, "R8 maxfin");
    drive(0, 300, 32'h80000000, 2'b10, 3'b000, {3'b101, 32'h7F7FFFFF}, "R8 down pos");
    drive(0, 253, 32'h80000000, 2'b00, 3'b000, {3'b000, 32'h7F000000}, "R8 edge below");
    drive(0, 254, 32'h80000000, 2'b00, 3'b000, {3'b101, 32'h7F800000}, "R8 edge at");
    drive(0, 255, 32'h40000000, 2'b00, 3'b000, {3'b101, 32'h7F800000}, "R8 e255 nonzero");
    drive(0, -1,  32'h80000000, 2'b00, 3'b000, {3'b000, 32'h00400000}, "R4 exact sub");
    drive(0, -24, 32'h80000000, 2'b00, 3'b000, {3'b011, 32'h00000000}, "R4 to zero");
    drive(0, -40, 32'h80000000, 2'b01, 3'b000, {3'b011, 32'h00000001}, "R4 far sticky");
    drive(0, -1,  32'hFFFFFF80, 2'b00, 3'b000, {3'b001, 32'h00800000}, "R4 min normal");
    drive(1, 50,  32'h00000000, 2'b00, 3'b000, {3'b000, 32'h80000000}, "R2 neg zero");
    drive(0, 50,  32'h00000000, 2'b01, 3'b010, {3'b010, 32'h00000000}, "R2 flags");
    drive(1, 255, 32'h00000000, 2'b00, 3'b000, {3'b000, 32'hFF800000}, "R1 inf");
    drive(0, 255, 32'h20000080, 2'b00, 3'b100, {3'b100, 32'h7FC00001}, "R1 nan");
    drive(0, 127, 32'h40000000, 2'b00, 3'b010, {3'b010, 32'h3F800000}, "R9 merge");

    // random mix under back-pressure
    bp_on = 1;
    for (int i = 0; i < 3000; i++) begin
      bit        s;
      int        e;
      bit [31:0] m;
      bit [1:0]  rm;
      bit [2:0]  fi;
      s  = 1'($urandom);
      rm = 2'($urandom);
      e  = int'($urandom % 401) - 100;
      if ($urandom % 20 == 0) e = 255;
      m  = $urandom >> ($urandom % 32);
      if ($urandom % 25 == 0) m = 0;
      fi = ($urandom % 8 == 0) ? 3'($urandom) : 3'b000;
      send(s, e, m, rm, fi, "R3 R5 R6 R7 random");
    end

    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule